// File: doc/BRIEF.md
# Match-Action Stage with Wide Per-Field Instruction

This block is one stage of a packet-processing pipeline built from match-action stages. Each stage receives a parsed header vector. The vector has a fixed number of equal-width fields and a single drop flag. The stage assembles a lookup key from fields chosen by configuration. It compares the key against a small ternary table. The comparison selects one wide instruction word. That word holds one small operation for every field of the vector. Every operation reads its operands from the vector as it entered the stage, and all results are written back in the same cycle. A chain of these stages gives sequential processing between stages and parallel processing within each stage.

A miss falls back to a configurable default instruction. Each table entry carries one immediate value. Operations can use that immediate as an operand, which makes constant edits possible: setting an egress field, decrementing a hop count, or loading a tag. One bit of the instruction marks the vector for dropping. Once set, the drop flag is never cleared by a later stage. A vector is accepted on every cycle, and its result appears exactly three cycles later.

Configuration is written through three simple write strobes: one for the key selectors, one for table entries and one for instruction words. The configuration port has no read-back path.

Top module: `mat_stage`

## Requirements
- R1: After reset, `out_valid` is 0, `out_hv` is 0 and `out_drop` is 0. All table entries are invalid, all instruction words are zero (every field NOP, no deny), and every key selector is 0.
- R2: A vector presented with `in_valid` high appears on `out_valid`/`out_hv`/`out_drop` exactly 3 clock edges later. A new vector can be accepted on every cycle, and results come out in input order.
- R3: Field i of the vector occupies `hv[i*FW +: FW]`. Key slot k occupies `key[k*FW +: FW]` and takes a copy of the field whose index is written in `cfg_key_sel[k*FSELW +: FSELW]`. A new selector takes effect for vectors that arrive after the write.
- R4: Entry e matches when its valid bit is set and `((key ^ value) & mask) == 0`. A mask bit of 1 means the key bit is compared, and a mask bit of 0 means it is ignored. An entry whose valid bit is clear never matches, even with an all-zero mask.
- R5: When several entries match, the entry with the lowest index wins.
- R6: On a miss, the stage uses the instruction word at address NENT (16 by default), and the immediate is 0. On a hit on entry e, it uses the instruction word at address e and that entry's immediate.
- R7: The instruction word is built from NFIELD slots of 9 bits each, with one deny bit on top at bit NFIELD*9. Slot i controls field i as follows: bits [2:0] are the opcode, [5:3] select operand A and [8:6] select operand B. The opcodes are 0 NOP (field kept), 1 COPY (A), 2 ADD (A+B), 3 SUB (A-B), 4 AND, 5 OR, 6 XOR and 7 LOAD-IMMEDIATE. Results wrap modulo 2^FW.
- R8: Every operand is read from the incoming vector, never from another slot's result in the same stage. Two slots that copy each other's field therefore swap the two fields.
- R9: An operand selector value of NFIELD or more selects the immediate of the matched entry instead of a field.
- R10: `out_drop` equals `in_drop` OR the deny bit of the selected instruction. An incoming drop flag is never cleared.
- R11: A configuration write changes only its target. The targets are the key selectors (`cfg_key_we`), entry `cfg_ent_addr` (`cfg_ent_we`) and instruction word `cfg_ins_addr` (`cfg_ins_we`, address 0 to NENT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming vector is valid this cycle |
| in_hv | input | NFIELD*FW | Incoming header vector |
| in_drop | input | 1 | Incoming drop flag |
| out_valid | output | 1 | Outgoing vector is valid |
| out_hv | output | NFIELD*FW | Edited header vector |
| out_drop | output | 1 | Outgoing drop flag |
| cfg_key_we | input | 1 | Write all key selectors |
| cfg_key_sel | input | NKEY*FSELW | Field index per key slot |
| cfg_ent_we | input | 1 | Write one table entry |
| cfg_ent_addr | input | IDXW | Entry index |
| cfg_ent_valid | input | 1 | Entry valid bit |
| cfg_ent_value | input | NKEY*FW | Entry compare value |
| cfg_ent_mask | input | NKEY*FW | Entry compare mask (1 = compare) |
| cfg_ent_imm | input | FW | Entry immediate |
| cfg_ins_we | input | 1 | Write one instruction word |
| cfg_ins_addr | input | INSAW | Instruction address, NENT = default |
| cfg_ins_data | input | NFIELD*9+1 | Instruction word |

## Verification
The bench goes after five corner cases.

- **Overlapping entries.** Two entries are set up so that both match the same vector. If the priority encoder chose the highest-index match, the wrong edit would appear.
- **Valid bit.** A fully wildcarded entry is left invalid. If its valid bit were ignored, every vector would hit it and the default instruction would never be seen.
- **Parallel read.** A field swap and an XOR that reads a field another slot overwrites are both exercised. If results were forwarded between slots inside the stage, these would produce duplicated or chained values.
- **Opcodes and operands.** The default instruction is swept through every opcode and every operand selector, including the immediate selector. On a miss the immediate must read as 0. This exposes wrong arithmetic, wrong slot bit positions and a stale immediate.
- **Drop flag.** Vectors arrive back-to-back with random incoming drop flags. This catches a lost drop flag, a wrong latency or reordered outputs.

// File: rtl/mat_pkg.sv
// Shared definitions for the match-action stage.
// Assumes: the opcode field of an instruction slot is 3 bits wide.
package mat_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 3'd0,
        OP_COPY = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_LDI  = 3'd7
    } op_e;
endpackage

// File: rtl/mat_keybuild.sv
// Builds the lookup key. Slot k takes a copy of the header field named by
// selector k.
// Assumes: a selector that is out of range yields a zero slot.
module mat_keybuild #(
    parameter int NFIELD = 4,
    parameter int FW     = 16,
    parameter int NKEY   = 2,
    parameter int FSELW  = 2
) (
    input  logic [NFIELD*FW-1:0]  hv,
    input  logic [NKEY*FSELW-1:0] sel,
    output logic [NKEY*FW-1:0]    key
);
    // Multiplex one selected field into each key slot.
    always_comb begin
        key = '0;
        for (int k = 0; k < NKEY; k++) begin
            for (int f = 0; f < NFIELD; f++) begin
                if (sel[k*FSELW +: FSELW] == FSELW'(f)) begin
                    key[k*FW +: FW] = hv[f*FW +: FW];
                end
            end
        end
    end
endmodule

// File: rtl/mat_tcam.sv
// Small ternary table held in registers. It compares one key per cycle
// combinationally. The lowest-index valid match wins. It returns hit, the
// index and the immediate, with the immediate forced to 0 on a miss.
// Assumes: writes happen on one port, and a read in the same cycle sees the
// old contents.
module mat_tcam #(
    parameter int NENT = 16,
    parameter int KEYW = 32,
    parameter int FW   = 16,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_addr,
    input  logic            wr_valid,
    input  logic [KEYW-1:0] wr_value,
    input  logic [KEYW-1:0] wr_mask,
    input  logic [FW-1:0]   wr_imm,
    input  logic [KEYW-1:0] key,
    output logic            hit,
    output logic [IDXW-1:0] hit_idx,
    output logic [FW-1:0]   hit_imm
);
    logic [NENT-1:0] ent_vld;
    logic [KEYW-1:0] ent_val [NENT];
    logic [KEYW-1:0] ent_msk [NENT];
    logic [FW-1:0]   ent_imm [NENT];
    logic [NENT-1:0] match_vec;

    // Entry storage: cleared on reset, one entry written per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            for (int i = 0; i < NENT; i++) begin
                ent_val[i] <= '0;
                ent_msk[i] <= '0;
                ent_imm[i] <= '0;
            end
        end else if (wr_en && (int'(wr_addr) < NENT)) begin
            ent_vld[wr_addr] <= wr_valid;
            ent_val[wr_addr] <= wr_value;
            ent_msk[wr_addr] <= wr_mask;
            ent_imm[wr_addr] <= wr_imm;
        end
    end

    // Masked compare of the key against every entry at once.
    for (genvar g = 0; g < NENT; g++) begin : g_cmp
        assign match_vec[g] = ent_vld[g] && (((key ^ ent_val[g]) & ent_msk[g]) == '0);
    end

    // Priority encoder: scan down so that the lowest index is assigned last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDXW'(i);
            end
        end
        hit_imm = hit ? ent_imm[hit_idx] : '0;
    end

    function automatic logic [NENT-1:0] below(input logic [IDXW-1:0] idx);
        logic [NENT-1:0] m;
        for (int i = 0; i < NENT; i++) m[i] = (i < int'(idx));
        return m;
    endfunction

    AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]);                                      // R4
    AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (match_vec == '0));                                      // R4
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & below(hit_idx)) == '0));                    // R5
endmodule

// File: rtl/mat_alu.sv
// Per-field ALU. It picks two operands from the incoming vector or the
// immediate, then applies one opcode to produce the new value of field FIDX.
// Assumes: operand selectors of NFIELD and above mean the immediate.
module mat_alu
    import mat_pkg::*;
#(
    parameter int NFIELD = 4,
    parameter int FW     = 16,
    parameter int SW     = 3,
    parameter int FIDX   = 0
) (
    input  logic [NFIELD*FW-1:0] hv,
    input  logic [FW-1:0]        imm,
    input  logic [OPW-1:0]       op,
    input  logic [SW-1:0]        sel_a,
    input  logic [SW-1:0]        sel_b,
    output logic [FW-1:0]        res
);
    logic [FW-1:0] opa, opb;

    // Operand fetch from the unmodified vector or the immediate.
    always_comb begin
        opa = imm;
        opb = imm;
        for (int f = 0; f < NFIELD; f++) begin
            if (sel_a == SW'(f)) opa = hv[f*FW +: FW];
            if (sel_b == SW'(f)) opb = hv[f*FW +: FW];
        end
    end

    // Opcode evaluation; NOP keeps the field.
    always_comb begin
        case (op_e'(op))
            OP_COPY: res = opa;
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            OP_AND:  res = opa & opb;
            OP_OR:   res = opa | opb;
            OP_XOR:  res = opa ^ opb;
            OP_LDI:  res = imm;
            default: res = hv[FIDX*FW +: FW];
        endcase
    end
endmodule

// File: rtl/mat_stage.sv
// One match-action stage with three registers: key build, match, execute.
// Each instruction slot drives the ALU of one field. All ALUs read the
// incoming vector and commit together. The deny bit ORs into the drop flag.
// Assumes: configuration is written while no vector is in flight, so that
// the result does not depend on the write timing.
module mat_stage
    import mat_pkg::*;
#(
    parameter int NFIELD = 4,
    parameter int FW     = 16,
    parameter int NKEY   = 2,
    parameter int NENT   = 16,
    localparam int HVW   = NFIELD * FW,
    localparam int KEYW  = NKEY * FW,
    localparam int FSELW = $clog2(NFIELD),
    localparam int SW    = $clog2(NFIELD + 1),
    localparam int SLOTW = OPW + 2 * SW,
    localparam int INSW  = NFIELD * SLOTW + 1,
    localparam int IDXW  = $clog2(NENT),
    localparam int INSAW = $clog2(NENT + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [HVW-1:0]        in_hv,
    input  logic                  in_drop,
    output logic                  out_valid,
    output logic [HVW-1:0]        out_hv,
    output logic                  out_drop,
    input  logic                  cfg_key_we,
    input  logic [NKEY*FSELW-1:0] cfg_key_sel,
    input  logic                  cfg_ent_we,
    input  logic [IDXW-1:0]       cfg_ent_addr,
    input  logic                  cfg_ent_valid,
    input  logic [KEYW-1:0]       cfg_ent_value,
    input  logic [KEYW-1:0]       cfg_ent_mask,
    input  logic [FW-1:0]         cfg_ent_imm,
    input  logic                  cfg_ins_we,
    input  logic [INSAW-1:0]      cfg_ins_addr,
    input  logic [INSW-1:0]       cfg_ins_data
);
    localparam int DENY_BIT = INSW - 1;

    logic [NKEY*FSELW-1:0] key_sel_q;
    logic [INSW-1:0]       ins_mem [NENT+1];

    logic                  s1_valid, s1_drop;
    logic [HVW-1:0]        s1_hv;
    logic [KEYW-1:0]       s1_key;
    logic [KEYW-1:0]       key_c;

    logic                  s2_valid, s2_drop, s2_hit;
    logic [HVW-1:0]        s2_hv;
    logic [IDXW-1:0]       s2_idx;
    logic [FW-1:0]         s2_imm;
    logic                  hit_c;
    logic [IDXW-1:0]       idx_c;
    logic [FW-1:0]         imm_c;

    logic [INSW-1:0]       ins_c;
    logic [HVW-1:0]        exec_c;

    // Key selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)          key_sel_q <= '0;
        else if (cfg_key_we) key_sel_q <= cfg_key_sel;
    end

    // Instruction memory: NENT entry words plus the default word at NENT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NENT; i++) ins_mem[i] <= '0;
        end else if (cfg_ins_we && (int'(cfg_ins_addr) <= NENT)) begin
            ins_mem[cfg_ins_addr] <= cfg_ins_data;
        end
    end

    mat_keybuild #(.NFIELD(NFIELD), .FW(FW), .NKEY(NKEY), .FSELW(FSELW)) u_key (
        .hv  (in_hv),
        .sel (key_sel_q),
        .key (key_c)
    );

    // Stage 1 register: vector, drop flag and built key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_drop  <= 1'b0;
            s1_hv    <= '0;
            s1_key   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_drop  <= in_drop;
            s1_hv    <= in_hv;
            s1_key   <= key_c;
        end
    end

    mat_tcam #(.NENT(NENT), .KEYW(KEYW), .FW(FW), .IDXW(IDXW)) u_tcam (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_ent_we),
        .wr_addr  (cfg_ent_addr),
        .wr_valid (cfg_ent_valid),
        .wr_value (cfg_ent_value),
        .wr_mask  (cfg_ent_mask),
        .wr_imm   (cfg_ent_imm),
        .key      (s1_key),
        .hit      (hit_c),
        .hit_idx  (idx_c),
        .hit_imm  (imm_c)
    );

    // Stage 2 register: match result travels with the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_drop  <= 1'b0;
            s2_hv    <= '0;
            s2_hit   <= 1'b0;
            s2_idx   <= '0;
            s2_imm   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_drop  <= s1_drop;
            s2_hv    <= s1_hv;
            s2_hit   <= hit_c;
            s2_idx   <= idx_c;
            s2_imm   <= imm_c;
        end
    end

    // Instruction fetch: the matched word, or the default word on a miss.
    assign ins_c = s2_hit ? ins_mem[INSAW'(s2_idx)] : ins_mem[NENT];

    for (genvar f = 0; f < NFIELD; f++) begin : g_alu
        mat_alu #(.NFIELD(NFIELD), .FW(FW), .SW(SW), .FIDX(f)) u_alu (
            .hv    (s2_hv),
            .imm   (s2_imm),
            .op    (ins_c[f*SLOTW +: OPW]),
            .sel_a (ins_c[f*SLOTW + OPW +: SW]),
            .sel_b (ins_c[f*SLOTW + OPW + SW +: SW]),
            .res   (exec_c[f*FW +: FW])
        );

        AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (s2_valid && (ins_c[f*SLOTW +: OPW] == OP_NOP))
            |=> (out_hv[f*FW +: FW] == $past(s2_hv[f*FW +: FW])));            // R7
    end

    // Stage 3 register: all field results commit together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hv    <= '0;
            out_drop  <= 1'b0;
        end else begin
            out_valid <= s2_valid;
            out_hv    <= exec_c;
            out_drop  <= s2_drop | ins_c[DENY_BIT];
        end
    end

    AST_ACCEPT_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);                                           // R2
    AST_EXEC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> out_valid);                                          // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_valid |=> !out_valid);                                        // R2
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_valid && s2_drop) |=> out_drop);                              // R10
endmodule

// File: tb/tb_mat_stage.sv
module tb_mat_stage;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 4, FW = 16, NK = 2, NE = 16;
    localparam int HVW = NF * FW, KEYW = NK * FW;
    localparam int SL = 9, INSW = NF * SL + 1;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_drop = 0;
    logic [HVW-1:0] in_hv = '0;
    logic out_valid, out_drop;
    logic [HVW-1:0] out_hv;
    logic cfg_key_we = 0, cfg_ent_we = 0, cfg_ent_valid = 0, cfg_ins_we = 0;
    logic [NK*2-1:0] cfg_key_sel = '0;
    logic [3:0] cfg_ent_addr = '0;
    logic [KEYW-1:0] cfg_ent_value = '0, cfg_ent_mask = '0;
    logic [FW-1:0] cfg_ent_imm = '0;
    logic [4:0] cfg_ins_addr = '0;
    logic [INSW-1:0] cfg_ins_data = '0;

    mat_stage dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench-side copy of the configuration.
    logic [1:0]      m_sel [NK];
    logic            m_vld [NE];
    logic [KEYW-1:0] m_val [NE];
    logic [KEYW-1:0] m_msk [NE];
    logic [FW-1:0]   m_imm [NE];
    logic [INSW-1:0] m_ins [NE+1];

    int nchk = 0, nfail = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    logic [HVW-1:0] q_hv[$];
    bit             q_drop[$];
    int             q_cyc[$];
    string          q_tag[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [SL-1:0] slot(input int op, input int sa, input int sb);
        return {3'(sb), 3'(sa), 3'(op)};
    endfunction

    function automatic logic [INSW-1:0] mk_ins(input bit deny, input logic [SL-1:0] s0, s1, s2, s3);
        return {deny, s3, s2, s1, s0};
    endfunction

    // Expected result computed from the requirement text (R3-R10).
    task automatic model(input logic [HVW-1:0] hv, input bit drop,
                         output logic [HVW-1:0] o, output bit od);
        logic [KEYW-1:0] key;
        logic [INSW-1:0] ins;
        logic [FW-1:0] imm, a, b, r;
        int e;
        e = -1;
        for (int k = 0; k < NK; k++) key[k*FW +: FW] = hv[int'(m_sel[k])*FW +: FW];
        for (int i = NE - 1; i >= 0; i--)
            if (m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == 0)) e = i;
        ins = (e >= 0) ? m_ins[e] : m_ins[NE];
        imm = (e >= 0) ? m_imm[e] : '0;
        for (int f = 0; f < NF; f++) begin
            int op, sa, sb;
            op = int'(ins[f*SL +: 3]);
            sa = int'(ins[f*SL+3 +: 3]);
            sb = int'(ins[f*SL+6 +: 3]);
            a = (sa < NF) ? hv[sa*FW +: FW] : imm;
            b = (sb < NF) ? hv[sb*FW +: FW] : imm;
            case (op)
                1: r = a;
                2: r = a + b;
                3: r = a - b;
                4: r = a & b;
                5: r = a | b;
                6: r = a ^ b;
                7: r = imm;
                default: r = hv[f*FW +: FW];
            endcase
            o[f*FW +: FW] = r;
        end
        od = drop | ins[INSW-1];
    endtask

    task automatic check(input string tag, input logic [HVW-1:0] act, input logic [HVW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished && out_valid) begin
            if (q_hv.size() == 0) begin
                check("R2 unexpected output", 1, 0);
            end else begin
                logic [HVW-1:0] eh;
                bit ed;
                int ec;
                string t;
                eh = q_hv.pop_front(); ed = q_drop.pop_front();
                ec = q_cyc.pop_front(); t = q_tag.pop_front();
                check({t, " vector"}, out_hv, eh);
                check({t, " R10 drop"}, HVW'(out_drop), HVW'(ed));
                check("R2 latency", HVW'(cyc - ec), HVW'(3));
            end
        end
    end

    task automatic send(input logic [HVW-1:0] hv, input bit drop, input string tag);
        logic [HVW-1:0] o;
        bit od;
        @(negedge clk);
        in_valid = 1; in_hv = hv; in_drop = drop;
        model(hv, drop, o, od);
        q_hv.push_back(o); q_drop.push_back(od); q_cyc.push_back(cyc); q_tag.push_back(tag);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 0; in_drop = 0;
        while (q_hv.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_key(input int s0, input int s1);
        @(negedge clk);
        cfg_key_we = 1; cfg_key_sel = {2'(s1), 2'(s0)};
        m_sel[0] = 2'(s0); m_sel[1] = 2'(s1);
        @(negedge clk); cfg_key_we = 0;
    endtask

    task automatic wr_ent(input int a, input bit v, input logic [KEYW-1:0] val, msk, input logic [FW-1:0] imm);
        @(negedge clk);
        cfg_ent_we = 1; cfg_ent_addr = 4'(a); cfg_ent_valid = v;
        cfg_ent_value = val; cfg_ent_mask = msk; cfg_ent_imm = imm;
        m_vld[a] = v; m_val[a] = val; m_msk[a] = msk; m_imm[a] = imm;
        @(negedge clk); cfg_ent_we = 0;
    endtask

    task automatic wr_ins(input int a, input logic [INSW-1:0] d);
        @(negedge clk);
        cfg_ins_we = 1; cfg_ins_addr = 5'(a); cfg_ins_data = d;
        m_ins[a] = d;
        @(negedge clk); cfg_ins_we = 0;
    endtask

    function automatic logic [HVW-1:0] hv4(input logic [FW-1:0] f0, f1, f2, f3);
        return {f3, f2, f1, f0};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_imm[i] = '0;
        end
        for (int i = 0; i <= NE; i++) m_ins[i] = '0;
        m_sel[0] = '0; m_sel[1] = '0;

        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state, checked over three idle cycles.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset valid", HVW'(out_valid), '0);
            check("R1 reset vector", out_hv, '0);
            check("R1 reset drop", HVW'(out_drop), '0);
        end
        // R1/R6: cleared tables give a miss with an all-NOP default.
        send(hv4(16'h1111, 16'h2222, 16'h3333, 16'h4444), 0, "R1 R6 empty table");
        drain();

        // Key: slot0 = field0, slot1 = field3 (R3).
        wr_key(0, 3);
        // R4: invalid fully wildcarded entry must never match.
        wr_ent(0, 0, '0, '0, 16'h7777);
        wr_ins(0, mk_ins(1, slot(7, 0, 0), slot(7, 0, 0), slot(7, 0, 0), slot(7, 0, 0)));
        // Entry 2: f0 == 0x0800, f1 = f1 - imm(1) (R9).
        wr_ent(2, 1, {16'h0000, 16'h0800}, {16'h0000, 16'hFFFF}, 16'h0001);
        wr_ins(2, mk_ins(0, slot(0, 0, 0), slot(3, 1, 4), slot(0, 0, 0), slot(0, 0, 0)));
        // Entry 4: overlaps entry 2 (R5), loads a marker.
        wr_ent(4, 1, {16'h0011, 16'h0800}, {16'hFFFF, 16'hFFFF}, 16'h0BAD);
        wr_ins(4, mk_ins(0, slot(0, 0, 0), slot(7, 0, 0), slot(0, 0, 0), slot(0, 0, 0)));
        // Entry 5: f0 == 0x86DD, f3[7:4] == 5; f2 = imm, f1 = f1 ^ f2 (R8).
        wr_ent(5, 1, {16'h0050, 16'h86DD}, {16'h00F0, 16'hFFFF}, 16'h0123);
        wr_ins(5, mk_ins(0, slot(0, 0, 0), slot(6, 1, 2), slot(7, 0, 0), slot(0, 0, 0)));
        // Entry 7: f3 == 0x00FF; deny, f1 = f1 + f2 (R10).
        wr_ent(7, 1, {16'h00FF, 16'h0000}, {16'hFFFF, 16'h0000}, 16'h0000);
        wr_ins(7, mk_ins(1, slot(0, 0, 0), slot(2, 1, 2), slot(0, 0, 0), slot(0, 0, 0)));
        // Default: f1 = f0 | f3, f2 = f0 (R6).
        wr_ins(NE, mk_ins(0, slot(0, 0, 0), slot(5, 0, 3), slot(1, 0, 0), slot(0, 0, 0)));

        // Directed vectors, back-to-back.
        send(hv4(16'h0800, 16'h0040, 16'h0007, 16'h00AA), 0, "R9 decrement via immediate");
        send(hv4(16'h0800, 16'h0040, 16'h0007, 16'h0011), 0, "R5 lowest index wins");
        send(hv4(16'h86DD, 16'h00F0, 16'h000F, 16'h005C), 0, "R4 R8 ternary and parallel read");
        send(hv4(16'h86DD, 16'h00F0, 16'h000F, 16'h0060), 0, "R6 miss default");
        send(hv4(16'h1234, 16'hFFFF, 16'h0002, 16'h00FF), 0, "R10 deny");
        send(hv4(16'h4321, 16'h0001, 16'h0002, 16'h0003), 1, "R10 incoming drop kept");
        drain();

        // Mixed traffic with gaps.
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            logic [FW-1:0] f0, f3;
            r = nxt();
            case (r[1:0])
                2'd0: f0 = 16'h0800;
                2'd1: f0 = 16'h86DD;
                2'd2: f0 = 16'h0806;
                default: f0 = r[31:16];
            endcase
            case (r[4:2])
                3'd0: f3 = 16'h00AA;
                3'd1: f3 = 16'h0011;
                3'd2, 3'd3: f3 = {12'h005, r[8:5]};
                3'd4: f3 = 16'h00FF;
                default: f3 = r[24:9];
            endcase
            if (r[12:10] == 0) begin
                @(negedge clk); in_valid = 0;
            end
            send(hv4(f0, nxt()[15:0], nxt()[15:0], f3), r[15:13] == 0, "R3 R4 R5 R6 R9 R10 traffic");
        end
        drain();

        // R3: key now from field2 (slot0) and field1 (slot1).
        wr_key(2, 1);
        send(hv4(16'h0000, 16'h0000, 16'h0800, 16'h00AA), 0, "R3 reselected key hit");
        send(hv4(16'h0800, 16'h0000, 16'h0000, 16'h00AA), 0, "R3 old key field ignored");
        for (int n = 0; n < 100; n++) begin
            logic [31:0] r;
            r = nxt();
            send(hv4(r[15:0], r[20] ? 16'h0050 : nxt()[15:0], r[21] ? 16'h86DD : 16'h0800, nxt()[15:0]),
                 0, "R3 reselected key traffic");
        end
        drain();

        // R8: swap fields 0 and 1 through the default instruction.
        for (int i = 0; i < NE; i++) wr_ent(i, 0, '0, '0, '0);
        wr_ins(NE, mk_ins(0, slot(1, 1, 0), slot(1, 0, 0), slot(0, 0, 0), slot(0, 0, 0)));
        send(hv4(16'hAAAA, 16'h5555, 16'h0000, 16'h0000), 0, "R8 swap");
        drain();

        // R11: an instruction write to entry 3 leaves the default untouched.
        wr_ins(3, mk_ins(1, slot(7, 0, 0), slot(7, 0, 0), slot(7, 0, 0), slot(7, 0, 0)));
        send(hv4(16'h0102, 16'h0304, 16'h0506, 16'h0708), 0, "R11 isolated write");
        drain();

        // R7/R9: sweep of the default instruction over opcodes and selectors.
        for (int op = 0; op < 8; op++) begin
            for (int sa = 0; sa < 5; sa++) begin
                for (int sb = 0; sb < 5; sb++) begin
                    wr_ins(NE, mk_ins(op[0],
                        slot(op, sa, sb), slot(op, (sa + 1) % 5, (sb + 2) % 5),
                        slot(op, (sa + 2) % 5, (sb + 4) % 5), slot(op, (sa + 3) % 5, (sb + 1) % 5)));
                    send(hv4(nxt()[15:0], nxt()[15:0], nxt()[15:0], nxt()[15:0]), 0, "R7 R9 opcode sweep");
                    send(hv4(16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF), nxt()[0], "R7 wrap sweep");
                    drain();
                end
            end
        end

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end
endmodule